// File: doc/BRIEF.md
# Eight-bit ALU with flags

This block is the arithmetic and logic stage of a small accumulator-style microcontroller core. Two 8-bit operands, a 4-bit operation code and a 3-bit bit index go in. An 8-bit result comes out combinationally. The result is meant for both the destination register and the accumulator copy. A separate strobe, `wr_dst_o`, tells the surrounding core whether the destination register should actually be written.

The block keeps the carry (C), overflow (V) and zero (Z) flags in registers of its own. They update on a clock edge only while `valid_i` is high, and only the flags that the operation owns change. The carry used by the with-carry operations is the registered C flag.

For every subtraction, C means "no borrow": C=1 means no borrow occurred. A with-carry subtraction or decrement therefore removes an extra (1 − C).

Operation codes on `op_i`:

| Code | Operation |
|------|-----------|
| 0 | decrement |
| 1 | decrement with carry |
| 2 | AND |
| 3 | OR |
| 4 | XOR |
| 5 | add |
| 6 | add with carry |
| 7 | reverse subtract (b − a) |
| 8 | reverse subtract with borrow |
| 9 | subtract (a − b) |
| 10 | subtract with borrow |
| 11 | compare |
| 12 | bit test |
| 13 | bit set |
| 14 | bit clear |
| 15 | bit invert |

Top module: `alu8_flags`

## Requirements
- R1: While `rst_ni` is low, and after it is released, C, V and Z are all 0.
- R2: Add (5) gives a+b, and add with carry (6) gives a+b+C. Both keep the low 8 bits and set C to the carry out of bit 7.
- R3: Subtract (9) gives a−b and reverse subtract (7) gives b−a. Their borrow forms (10, 8) take off a further (1−C). C becomes 0 on a borrow and 1 otherwise.
- R4: Decrement (0) gives a−1, with C=0 only when the result is 0xFF. Decrement with carry (1) gives a−(1−C), with C=0 only when the result is 0xFF and the incoming C was 0.
- R5: Compare (11) puts b−a on `res_o` and holds `wr_dst_o` at 0. It sets C as for a subtraction and Z from the difference, and sets V to C AND NOT Z.
- R6: AND (2), OR (3) and XOR (4) give the bitwise result of a and b. They update Z only; C and V keep their values.
- R7: Bit test (12) copies bit `idx_i` of a into the same position of `res_o` and drives all other bits to 0. It holds `wr_dst_o` at 0 and updates Z only.
- R8: Bit set (13), clear (14) and invert (15) return a with only bit `idx_i` forced to 1, forced to 0 or flipped. They update Z only.
- R9: For every operation executed with `valid_i` high, Z becomes 1 exactly when the 8-bit result was 0.
- R10: For add, subtract, decrement and their carry forms, V becomes the signed two's-complement overflow of the effective operation.
- R11: While `valid_i` is low, C, V and Z keep their values whatever the other inputs do.
- R12: `wr_dst_o` is 1 for every operation except compare and bit test.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Execute strobe; the flags update on this edge |
| op_i | input | 4 | Operation code |
| a_i | input | 8 | First operand (register operand) |
| b_i | input | 8 | Second operand |
| idx_i | input | 3 | Bit index for the bit operations |
| res_o | output | 8 | Result, for both the destination and the accumulator |
| wr_dst_o | output | 1 | Destination write enable |
| c_o | output | 1 | Carry / no-borrow flag |
| v_o | output | 1 | Overflow flag |
| z_o | output | 1 | Zero flag |

## Verification
The assertions assume that `op_i`, `a_i` and `b_i` are stable across the sampling edge, so that the result sampled there is the one the flags were computed from. The stimulus meets this by changing inputs only on the falling edge and holding them through the next rising edge.

Every one of the 16 codes is legal, so no opcode constraint is needed. The carry-in is never driven directly: each vector first loads chosen C and V values with an add of fixed operands. The vector then relies only on that registered state.

// File: rtl/alu8_pkg.sv
`timescale 1ns/1ps
package alu8_pkg;
  typedef enum logic [3:0] {
    OP_DEC   = 4'd0,
    OP_DECC  = 4'd1,
    OP_AND   = 4'd2,
    OP_OR    = 4'd3,
    OP_XOR   = 4'd4,
    OP_ADD   = 4'd5,
    OP_ADDC  = 4'd6,
    OP_SUBR  = 4'd7,
    OP_SUBRC = 4'd8,
    OP_SUB   = 4'd9,
    OP_SUBC  = 4'd10,
    OP_CMP   = 4'd11,
    OP_TST   = 4'd12,
    OP_SETB  = 4'd13,
    OP_CLRB  = 4'd14,
    OP_INVB  = 4'd15
  } op_e;

  function automatic logic is_arith(op_e op);
    return (op == OP_DEC) || (op == OP_DECC) || (op == OP_ADD) || (op == OP_ADDC) ||
           (op == OP_SUBR) || (op == OP_SUBRC) || (op == OP_SUB) || (op == OP_SUBC) ||
           (op == OP_CMP);
  endfunction
endpackage

// File: rtl/alu8_addsub.sv
`timescale 1ns/1ps
module alu8_addsub
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  op_e          op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         c_i,
  output logic [W-1:0] sum_o,
  output logic         c_o,
  output logic         v_o
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] x, y, y_eff;
  logic         sub, bin, cin;
  logic [W:0]   sum;

  // Operand steering; borrow-in is (1 - C) for the with-carry subtract forms
  always_comb begin
    x   = a_i;
    y   = b_i;
    sub = 1'b1;
    bin = 1'b0;
    cin = 1'b0;
    unique case (op_i)
      OP_DEC:   begin y = ONE; end
      OP_DECC:  begin y = '0; bin = ~c_i; end
      OP_ADD:   begin sub = 1'b0; end
      OP_ADDC:  begin sub = 1'b0; cin = c_i; end
      OP_SUBR:  begin x = b_i; y = a_i; end
      OP_SUBRC: begin x = b_i; y = a_i; bin = ~c_i; end
      OP_SUB:   begin end
      OP_SUBC:  begin bin = ~c_i; end
      OP_CMP:   begin x = b_i; y = a_i; end
      default:  begin sub = 1'b0; end
    endcase
  end

  // One adder: subtraction is x + ~y + ~borrow, carry out equals no-borrow
  assign y_eff = sub ? ~y : y;
  assign sum   = {1'b0, x} + {1'b0, y_eff} + {{W{1'b0}}, (sub ? ~bin : cin)};
  assign sum_o = sum[W-1:0];
  assign c_o   = sum[W];
  assign v_o   = (x[W-1] == y_eff[W-1]) && (sum[W-1] != x[W-1]);
endmodule

// File: rtl/alu8_bitlogic.sv
`timescale 1ns/1ps
module alu8_bitlogic
  import alu8_pkg::*;
#(
  parameter int W  = 8,
  localparam int IW = $clog2(W)
) (
  input  op_e           op_i,
  input  logic [W-1:0]  a_i,
  input  logic [W-1:0]  b_i,
  input  logic [IW-1:0] idx_i,
  output logic [W-1:0]  res_o
);
  logic [W-1:0] mask;

  assign mask = {{(W-1){1'b0}}, 1'b1} << idx_i;

  always_comb begin
    unique case (op_i)
      OP_AND:  res_o = a_i & b_i;
      OP_OR:   res_o = a_i | b_i;
      OP_XOR:  res_o = a_i ^ b_i;
      OP_TST:  res_o = a_i & mask;
      OP_SETB: res_o = a_i | mask;
      OP_CLRB: res_o = a_i & ~mask;
      OP_INVB: res_o = a_i ^ mask;
      default: res_o = '0;
    endcase
  end
endmodule

// File: rtl/alu8_flag_reg.sv
`timescale 1ns/1ps
module alu8_flag_reg #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         valid_i,
  input  logic         upd_cv_i,
  input  logic         cmp_i,
  input  logic [W-1:0] res_i,
  input  logic         c_i,
  input  logic         v_i,
  output logic         c_o,
  output logic         v_o,
  output logic         z_o
);
  logic zero;

  assign zero = (res_i == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      c_o <= 1'b0;
      v_o <= 1'b0;
      z_o <= 1'b0;
    end else if (valid_i) begin
      z_o <= zero;
      if (upd_cv_i) begin
        c_o <= c_i;
        // compare reports strict greater-than in V
        v_o <= cmp_i ? (c_i & ~zero) : v_i;
      end
    end
  end
endmodule

// File: rtl/alu8_flags.sv
`timescale 1ns/1ps
module alu8_flags
  import alu8_pkg::*;
#(
  parameter int W  = 8,
  localparam int IW = $clog2(W)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic [3:0]    op_i,
  input  logic [W-1:0]  a_i,
  input  logic [W-1:0]  b_i,
  input  logic [IW-1:0] idx_i,
  output logic [W-1:0]  res_o,
  output logic          wr_dst_o,
  output logic          c_o,
  output logic          v_o,
  output logic          z_o
);
  op_e          op;
  logic         arith;
  logic [W-1:0] as_res, bl_res;
  logic         as_c, as_v;

  assign op    = op_e'(op_i);
  assign arith = is_arith(op);

  alu8_addsub #(.W(W)) i_addsub (
    .op_i  (op),
    .a_i   (a_i),
    .b_i   (b_i),
    .c_i   (c_o),
    .sum_o (as_res),
    .c_o   (as_c),
    .v_o   (as_v)
  );

  alu8_bitlogic #(.W(W)) i_bitlogic (
    .op_i  (op),
    .a_i   (a_i),
    .b_i   (b_i),
    .idx_i (idx_i),
    .res_o (bl_res)
  );

  assign res_o    = arith ? as_res : bl_res;
  assign wr_dst_o = !((op == OP_CMP) || (op == OP_TST));

  alu8_flag_reg #(.W(W)) i_flag_reg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .valid_i  (valid_i),
    .upd_cv_i (arith),
    .cmp_i    (op == OP_CMP),
    .res_i    (res_o),
    .c_i      (as_c),
    .v_i      (as_v),
    .c_o      (c_o),
    .v_o      (v_o),
    .z_o      (z_o)
  );
endmodule

// File: rtl/alu8_flags_chk.sv
`timescale 1ns/1ps
module alu8_flags_chk
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         valid_i,
  input logic [3:0]   op_i,
  input logic [W-1:0] a_i,
  input logic [W-1:0] b_i,
  input logic [W-1:0] res_o,
  input logic         wr_dst_o,
  input logic         c_o,
  input logic         v_o,
  input logic         z_o
);
  logic [W:0] add_ref;
  logic       logic_op;

  assign add_ref  = {1'b0, a_i} + {1'b0, b_i};
  assign logic_op = (op_i == OP_AND) || (op_i == OP_OR) || (op_i == OP_XOR) ||
                    (op_i == OP_TST) || (op_i == OP_SETB) || (op_i == OP_CLRB) ||
                    (op_i == OP_INVB);

  p_add_carry_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == OP_ADD) |=> (c_o == $past(add_ref[W])));

  p_cmp_gt_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == OP_CMP) |=> (v_o == (c_o && !z_o)));

  p_cv_keep_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && logic_op) |=> ($stable(c_o) && $stable(v_o)));

  p_tst_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_TST) |-> $onehot0(res_o));

  p_zero_flag_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> (z_o == ($past(res_o) == '0)));

  p_flags_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(c_o) && $stable(v_o) && $stable(z_o)));

  p_no_write_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_CMP || op_i == OP_TST) |-> !wr_dst_o);

  p_write_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(op_i == OP_CMP || op_i == OP_TST) |-> wr_dst_o);
endmodule

bind alu8_flags alu8_flags_chk #(.W(W)) i_chk (.*);

// File: tb/test_alu8_flags.sv
`timescale 1ns/1ps
module test_alu8_flags;
  typedef struct packed {
    logic [3:0] op;
    logic [7:0] a;
    logic [7:0] b;
    logic [2:0] idx;
    logic       cin;
    logic       vin;
    logic [7:0] res;
    logic       c;
    logic       v;
    logic       z;
    logic       wr;
  } vec_t;

  localparam int NV = 37;
  //                 op     a      b      idx   cin   vin   res    c     v     z     wr
  localparam vec_t VEC [NV] = '{
    // R2 add / add with carry
    '{4'd5,  8'h3C, 8'h0A, 3'd0, 1'b0, 1'b0, 8'h46, 1'b0, 1'b0, 1'b0, 1'b1},
    '{4'd5,  8'hFF, 8'h01, 3'd0, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 1'b1},
    '{4'd5,  8'h7F, 8'h01, 3'd0, 1'b0, 1'b0, 8'h80, 1'b0, 1'b1, 1'b0, 1'b1},
    '{4'd5,  8'h80, 8'h80, 3'd0, 1'b0, 1'b0, 8'h00, 1'b1, 1'b1, 1'b1, 1'b1},
    '{4'd6,  8'h10, 8'h20, 3'd0, 1'b1, 1'b0, 8'h31, 1'b0, 1'b0, 1'b0, 1'b1},
    '{4'd6,  8'hFF, 8'h00, 3'd0, 1'b1, 1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 1'b1},
    // R3 subtract in both orders, with and without borrow
    '{4'd9,  8'h50, 8'h20, 3'd0, 1'b0, 1'b0, 8'h30, 1'b1, 1'b0, 1'b0, 1'b1},
    '{4'd9,  8'h20, 8'h50, 3'd0, 1'b0, 1'b0, 8'hD0, 1'b0, 1'b0, 1'b0, 1'b1},
    '{4'd9,  8'h80, 8'h01, 3'd0, 1'b0, 1'b0, 8'h7F, 1'b1, 1'b1, 1'b0, 1'b1},
    '{4'd7,  8'h20, 8'h50, 3'd0, 1'b0, 1'b0, 8'h30, 1'b1, 1'b0, 1'b0, 1'b1},
    '{4'd7,  8'h50, 8'h20, 3'd0, 1'b0, 1'b0, 8'hD0, 1'b0, 1'b0, 1'b0, 1'b1},
    '{4'd10, 8'h50, 8'h20, 3'd0, 1'b0, 1'b0, 8'h2F, 1'b1, 1'b0, 1'b0, 1'b1},
    '{4'd10, 8'h20, 8'h20, 3'd0, 1'b0, 1'b0, 8'hFF, 1'b0, 1'b0, 1'b0, 1'b1},
    '{4'd10, 8'h20, 8'h20, 3'd0, 1'b1, 1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 1'b1},
    '{4'd8,  8'h01, 8'h01, 3'd0, 1'b0, 1'b0, 8'hFF, 1'b0, 1'b0, 1'b0, 1'b1},
    '{4'd8,  8'h05, 8'h09, 3'd0, 1'b1, 1'b0, 8'h04, 1'b1, 1'b0, 1'b0, 1'b1},
    // R4 decrement forms
    '{4'd0,  8'h00, 8'h00, 3'd0, 1'b1, 1'b0, 8'hFF, 1'b0, 1'b0, 1'b0, 1'b1},
    '{4'd0,  8'h01, 8'h00, 3'd0, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 1'b1},
    '{4'd0,  8'h80, 8'h00, 3'd0, 1'b0, 1'b0, 8'h7F, 1'b1, 1'b1, 1'b0, 1'b1},
    '{4'd1,  8'h00, 8'h00, 3'd0, 1'b0, 1'b0, 8'hFF, 1'b0, 1'b0, 1'b0, 1'b1},
    '{4'd1,  8'h00, 8'h00, 3'd0, 1'b1, 1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 1'b1},
    '{4'd1,  8'hFF, 8'h00, 3'd0, 1'b0, 1'b0, 8'hFE, 1'b1, 1'b0, 1'b0, 1'b1},
    '{4'd1,  8'hFF, 8'h00, 3'd0, 1'b1, 1'b0, 8'hFF, 1'b1, 1'b0, 1'b0, 1'b1},
    // R5 compare
    '{4'd11, 8'h10, 8'h30, 3'd0, 1'b0, 1'b0, 8'h20, 1'b1, 1'b1, 1'b0, 1'b0},
    '{4'd11, 8'h30, 8'h30, 3'd0, 1'b0, 1'b1, 8'h00, 1'b1, 1'b0, 1'b1, 1'b0},
    '{4'd11, 8'h30, 8'h10, 3'd0, 1'b1, 1'b1, 8'hE0, 1'b0, 1'b0, 1'b0, 1'b0},
    // R6 logic ops keep C and V
    '{4'd2,  8'hF0, 8'h3C, 3'd0, 1'b1, 1'b1, 8'h30, 1'b1, 1'b1, 1'b0, 1'b1},
    '{4'd2,  8'hF0, 8'h0F, 3'd0, 1'b0, 1'b1, 8'h00, 1'b0, 1'b1, 1'b1, 1'b1},
    '{4'd3,  8'hA0, 8'h05, 3'd0, 1'b1, 1'b1, 8'hA5, 1'b1, 1'b1, 1'b0, 1'b1},
    '{4'd4,  8'h5A, 8'h5A, 3'd0, 1'b0, 1'b1, 8'h00, 1'b0, 1'b1, 1'b1, 1'b1},
    // R7 bit test
    '{4'd12, 8'h84, 8'hFF, 3'd2, 1'b1, 1'b1, 8'h04, 1'b1, 1'b1, 1'b0, 1'b0},
    '{4'd12, 8'h84, 8'hFF, 3'd3, 1'b0, 1'b1, 8'h00, 1'b0, 1'b1, 1'b1, 1'b0},
    // R8 bit set / clear / invert
    '{4'd13, 8'h00, 8'h00, 3'd7, 1'b1, 1'b1, 8'h80, 1'b1, 1'b1, 1'b0, 1'b1},
    '{4'd13, 8'hFF, 8'h00, 3'd3, 1'b0, 1'b1, 8'hFF, 1'b0, 1'b1, 1'b0, 1'b1},
    '{4'd14, 8'h01, 8'h00, 3'd0, 1'b0, 1'b1, 8'h00, 1'b0, 1'b1, 1'b1, 1'b1},
    '{4'd15, 8'hFF, 8'h00, 3'd4, 1'b1, 1'b1, 8'hEF, 1'b1, 1'b1, 1'b0, 1'b1},
    '{4'd15, 8'h10, 8'h00, 3'd4, 1'b0, 1'b1, 8'h00, 1'b0, 1'b1, 1'b1, 1'b1}
  };

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       valid_i = 1'b0;
  logic [3:0] op_i = 4'd0;
  logic [7:0] a_i = 8'h00;
  logic [7:0] b_i = 8'h00;
  logic [2:0] idx_i = 3'd0;
  logic [7:0] res_o;
  logic       wr_dst_o, c_o, v_o, z_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  alu8_flags i_alu8_flags (
    .clk_i, .rst_ni, .valid_i, .op_i, .a_i, .b_i, .idx_i,
    .res_o, .wr_dst_o, .c_o, .v_o, .z_o
  );

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual %0d expected below 20000 cycles", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic string req_of(input logic [3:0] op);
    case (op)
      4'd0, 4'd1:               return "R4";
      4'd2, 4'd3, 4'd4:         return "R6";
      4'd5, 4'd6:               return "R2";
      4'd7, 4'd8, 4'd9, 4'd10:  return "R3";
      4'd11:                    return "R5";
      4'd12:                    return "R7";
      default:                  return "R8";
    endcase
  endfunction

  // Loads C and V through an add with fixed operands
  task automatic preload(input logic cin, input logic vin);
    @(negedge clk_i);
    valid_i = 1'b1;
    op_i    = 4'd5;
    case ({cin, vin})
      2'b00: begin a_i = 8'h00; b_i = 8'h00; end
      2'b10: begin a_i = 8'hFF; b_i = 8'h01; end
      2'b01: begin a_i = 8'h7F; b_i = 8'h01; end
      default: begin a_i = 8'h80; b_i = 8'h80; end
    endcase
    @(posedge clk_i);
  endtask

  task automatic flags_chk(input string rq, input string rqv, input logic c, v, z);
    chk(c_o == c, rq, "C", {7'd0, c_o}, {7'd0, c});
    chk(v_o == v, rqv, "V", {7'd0, v_o}, {7'd0, v});
    chk(z_o == z, "R9", "Z", {7'd0, z_o}, {7'd0, z});
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    #1;
    flags_chk("R1", "R1", 1'b0, 1'b0, 1'b0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(posedge clk_i);
    #1;
    flags_chk("R1", "R1", 1'b0, 1'b0, 1'b0);

    for (int i = 0; i < NV; i++) begin
      string rq, rqv;
      rq  = req_of(VEC[i].op);
      rqv = (VEC[i].op == 4'd11 || VEC[i].op >= 4'd12 ||
             (VEC[i].op >= 4'd2 && VEC[i].op <= 4'd4)) ? rq : "R10";
      preload(VEC[i].cin, VEC[i].vin);
      @(negedge clk_i);
      valid_i = 1'b1;
      op_i    = VEC[i].op;
      a_i     = VEC[i].a;
      b_i     = VEC[i].b;
      idx_i   = VEC[i].idx;
      #1;
      chk(res_o == VEC[i].res, rq, "result", res_o, VEC[i].res);
      chk(wr_dst_o == VEC[i].wr, "R12", "wr_dst", {7'd0, wr_dst_o}, {7'd0, VEC[i].wr});
      @(posedge clk_i);
      #1;
      flags_chk(rq, rqv, VEC[i].c, VEC[i].v, VEC[i].z);
    end

    // R11: a would-be add with valid low leaves all flags alone
    preload(1'b1, 1'b1);
    @(negedge clk_i);
    valid_i = 1'b0;
    op_i    = 4'd5;
    a_i     = 8'h01;
    b_i     = 8'h02;
    repeat (2) @(posedge clk_i);
    #1;
    flags_chk("R11", "R11", 1'b1, 1'b1, 1'b1);

    // R1: reset in the middle of operation clears the flags
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    flags_chk("R1", "R1", 1'b0, 1'b0, 1'b0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule